// File: doc/BRIEF.md
# Pixel Output Blanking and Formatting Stage

This block is the last stage on a 12-bit image-sensor pixel path. It sits after the converter and takes one sample per data-clock period. It also takes a preblanking strobe and a clamp strobe, each sampled alongside the pixel. The sample and both strobes travel together down a fixed-depth delay line. At the far end, the word is either passed through or blanked. A blanked word is forced to zero or to the programmed black level. The result can then be converted to Gray code and placed on the output bus.

The data clock, the clamp strobe and the preblanking strobe each have their own polarity input. The delay line advances only on the active edge of the data clock. That edge is detected in the system clock domain. In registered mode the formatted word is captured into an output register on the last active edge. In transparent mode the output follows the formatted word directly, one data-clock period sooner. The pad tri-state is modelled as an output-enable signal.

Top module: `pix_out_stage`

## Requirements
- R1: During and directly after reset, `dout` is 0 and every pipeline stage holds a zero sample with both strobes inactive.
- R2: In registered mode, a sample presented at one active data-clock edge appears on `dout` right after the ninth active edge, counting that edge as the first. After only eight edges the earlier content is still shown.
- R3: The pipeline and `dout` change only on an active data-clock edge. That edge is a rising edge of `dclk_in` when `dclk_pol`=1 and a falling edge when `dclk_pol`=0. With no such edge, `dout` holds its value in registered mode.
- R4: A strobe is active when its raw level equals its polarity bit (1 = active-high, 0 = active-low). A sample tagged with active preblanking and inactive clamp leaves as 0 when `blank_to_clamp`=0.
- R5: With `blank_to_clamp`=1, a blanked sample leaves as the 8-bit `clamp_level` placed in bits 7:0, with bits 11:8 at zero.
- R6: When the clamp strobe is active for a sample, that sample is never blanked, whatever the preblanking strobe is.
- R7: With `gray_en`=1 the output word is w XOR (w >> 1), where w is the word after blanking. With `gray_en`=0 the word is straight binary.
- R8: `dout_oe` is 0 while `hiz_en`=1 and 1 otherwise. `hiz_en` has no effect on the `dout` value.
- R9: With `transparent`=1, `dout` shows the formatted word from the stage ahead of the output register. A sample is therefore visible right after its eighth active edge.
- R10: A strobe affects only the sample it was captured with. A sample blanked at one edge does not blank the sample captured at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dclk_in | input | 1 | Raw data clock, sampled in the `clk` domain |
| dclk_pol | input | 1 | Data-clock active edge: 1 rising, 0 falling |
| adc_data | input | 12 | Converter sample |
| pblk_in | input | 1 | Raw preblanking strobe |
| pblk_pol | input | 1 | Preblanking polarity: 1 active-high, 0 active-low |
| clpob_in | input | 1 | Raw clamp strobe |
| clpob_pol | input | 1 | Clamp-strobe polarity: 1 active-high, 0 active-low |
| blank_to_clamp | input | 1 | Blank value: 0 zero, 1 clamp level |
| clamp_level | input | 8 | Black level used as the blank value |
| gray_en | input | 1 | Output coding: 0 binary, 1 Gray |
| hiz_en | input | 1 | 1 releases the data bus (drives `dout_oe` low) |
| transparent | input | 1 | 1 bypasses the output register |
| dout | output | 12 | Formatted pixel word |
| dout_oe | output | 1 | Output enable for the pad drivers |

## Verification
The bench builds the block with its default parameters: a 12-bit word, an 8-bit clamp level and a latency of nine. With these values the exact nine-edge and eight-edge boundaries can be checked in registered and transparent mode. The clamp level fills the low byte of the word, so a Gray-coded clamp value can be checked. Because the data clock is a slow strobe against the 50 MHz system clock, the bench can hold the data clock idle for many system cycles and show that nothing moves. It can also flip the data-clock polarity so that the pipeline advances on the opposite edge.

// File: rtl/pix_out_pkg.sv
// Shared definitions for the pixel output stage.
// Assumes: blank-mode selection is a single configuration bit.
package pix_out_pkg;
    // Default number of active data-clock edges from input to output.
    localparam int PIX_LAT_DEFAULT = 9;

    // Value substituted for a blanked pixel.
    typedef enum logic {
        BLANK_TO_ZERO  = 1'b0,
        BLANK_TO_CLAMP = 1'b1
    } blank_mode_e;
endpackage

// File: rtl/pix_edge_det.sv
// Detects the active edge of a raw data clock in the system clock domain.
// Assumes: the raw clock is slow against clk and already synchronous.
// After reset the previous level reads as active, so no false edge is seen.
module pix_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    output logic adv
);
    logic norm;
    logic norm_q;

    // Map the raw level so that 1 always means the active phase.
    assign norm = pol ? raw : ~raw;

    // Remember last cycle's normalised level.
    always_ff @(posedge clk) begin
        if (!rst_n) norm_q <= 1'b1;
        else        norm_q <= norm;
    end

    // One-cycle pulse on entry into the active phase.
    assign adv = norm & ~norm_q;
endmodule

// File: rtl/pix_delay_line.sv
// Parameterised shift register that steps only when enabled.
// Assumes: DEPTH >= 1; every stage resets to zero.
module pix_delay_line #(
    parameter int W     = 14,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH+1];

    assign stg[0] = d;

    for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
        // Each stage takes the previous stage's word on an enable pulse.
        always_ff @(posedge clk) begin
            if (!rst_n)  stg[i] <= '0;
            else if (en) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH];
endmodule

// File: rtl/pix_formatter.sv
// Applies blanking (clamp strobe has priority) and optional Gray coding.
// Assumes: DW > CLW; the clamp level fills the low bits of the word.
module pix_formatter
    import pix_out_pkg::*;
#(
    parameter int DW  = 12,
    parameter int CLW = 8
) (
    input  logic [DW-1:0]  data,
    input  logic           pb_act,
    input  logic           cl_act,
    input  logic           blank_to_clamp,
    input  logic [CLW-1:0] clamp_level,
    input  logic           gray_en,
    output logic [DW-1:0]  word
);
    localparam int PAD = DW - CLW;

    blank_mode_e   mode;
    logic          blank;
    logic [DW-1:0] blank_val;
    logic [DW-1:0] sel;

    assign mode = blank_mode_e'(blank_to_clamp);

    // Blank only when the clamp strobe is not also present.
    assign blank = pb_act & ~cl_act;

    // Pick the substitute value for a blanked pixel.
    always_comb begin
        if (mode == BLANK_TO_CLAMP) blank_val = {{PAD{1'b0}}, clamp_level};
        else                        blank_val = '0;
    end

    // Blanking mux followed by the coding stage.
    always_comb begin
        sel  = blank ? blank_val : data;
        word = gray_en ? (sel ^ (sel >> 1)) : sel;
    end
endmodule

// File: rtl/pix_out_stage.sv
// Pixel output stage: aligns pixel and strobes through a fixed pipeline,
// formats the word and registers or passes it to the output bus.
// Assumes: LAT >= 2; inputs are synchronous to clk; dclk_in is slow.
module pix_out_stage
    import pix_out_pkg::*;
#(
    parameter int DW  = 12,
    parameter int CLW = 8,
    parameter int LAT = PIX_LAT_DEFAULT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dclk_in,
    input  logic           dclk_pol,
    input  logic [DW-1:0]  adc_data,
    input  logic           pblk_in,
    input  logic           pblk_pol,
    input  logic           clpob_in,
    input  logic           clpob_pol,
    input  logic           blank_to_clamp,
    input  logic [CLW-1:0] clamp_level,
    input  logic           gray_en,
    input  logic           hiz_en,
    input  logic           transparent,
    output logic [DW-1:0]  dout,
    output logic           dout_oe
);
    localparam int PIPE_W = DW + 2;
    localparam int DEPTH  = LAT - 1;

    logic              adv;
    logic              pb_now;
    logic              cl_now;
    logic [PIPE_W-1:0] pipe_q;
    logic [DW-1:0]     end_data;
    logic              end_pb;
    logic              end_cl;
    logic [DW-1:0]     fmt_word;
    logic [DW-1:0]     out_q;

    pix_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (dclk_in),
        .pol   (dclk_pol),
        .adv   (adv)
    );

    // Normalise strobes so that 1 means active before they enter the pipe.
    assign pb_now = pblk_pol  ? pblk_in  : ~pblk_in;
    assign cl_now = clpob_pol ? clpob_in : ~clpob_in;

    pix_delay_line #(.W(PIPE_W), .DEPTH(DEPTH)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv),
        .d     ({pb_now, cl_now, adc_data}),
        .q     (pipe_q)
    );

    assign {end_pb, end_cl, end_data} = pipe_q;

    pix_formatter #(.DW(DW), .CLW(CLW)) u_fmt (
        .data           (end_data),
        .pb_act         (end_pb),
        .cl_act         (end_cl),
        .blank_to_clamp (blank_to_clamp),
        .clamp_level    (clamp_level),
        .gray_en        (gray_en),
        .word           (fmt_word)
    );

    // Final latency stage: capture the formatted word on each active edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_q <= '0;
        else if (adv) out_q <= fmt_word;
    end

    // Registered or transparent output, plus pad enable.
    assign dout    = transparent ? fmt_word : out_q;
    assign dout_oe = ~hiz_en;
endmodule

// File: rtl/pix_out_stage_chk.sv
// Property checker for pix_out_stage, bound into every instance.
// Assumes: observes top ports plus the pipeline's end-of-line fields.
module pix_out_stage_chk #(
    parameter int DW  = 12,
    parameter int CLW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dclk_in,
    input logic           dclk_pol,
    input logic           transparent,
    input logic           gray_en,
    input logic           blank_to_clamp,
    input logic [CLW-1:0] clamp_level,
    input logic [DW-1:0]  dout,
    input logic [DW-1:0]  end_data,
    input logic           end_pb,
    input logic           end_cl
);
    logic lvl;
    logic lvl_q;
    logic edge_seen;

    assign lvl = dclk_pol ? dclk_in : ~dclk_in;

    // Independent record of the previous data-clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

    assign edge_seen = lvl & ~lvl_q;

    // R3: registered output holds without an active edge.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!transparent && !edge_seen) |=> (transparent || $stable(dout)));

    // R4: blanked sample without clamp goes to zero.
    assert_blank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !transparent && end_pb && !end_cl && !blank_to_clamp && !gray_en)
        |=> (transparent || dout == '0));

    // R5: blanked sample in clamp mode goes to the clamp level.
    assert_blank_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !transparent && end_pb && !end_cl && blank_to_clamp && !gray_en)
        |=> (transparent || dout == {{(DW-CLW){1'b0}}, $past(clamp_level)}));

    // R6: clamp strobe keeps the sample intact.
    assert_clamp_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !transparent && end_cl && !gray_en)
        |=> (transparent || dout == $past(end_data)));

    // R9: transparent binary output equals the unblanked end-of-pipe sample.
    assert_transparent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (transparent && !gray_en && !end_pb) |-> (dout == end_data));
endmodule

bind pix_out_stage pix_out_stage_chk #(.DW(DW), .CLW(CLW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dclk_in        (dclk_in),
    .dclk_pol       (dclk_pol),
    .transparent    (transparent),
    .gray_en        (gray_en),
    .blank_to_clamp (blank_to_clamp),
    .clamp_level    (clamp_level),
    .dout           (dout),
    .end_data       (end_data),
    .end_pb         (end_pb),
    .end_cl         (end_cl)
);

// File: tb/pix_out_stage_test.sv
// Self-checking bench for pix_out_stage: table walk then directed tests.
module pix_out_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dclk_in = 1'b0;
    logic        dclk_pol = 1'b1;
    logic [11:0] adc_data = '0;
    logic        pblk_in = 1'b0;
    logic        pblk_pol = 1'b1;
    logic        clpob_in = 1'b0;
    logic        clpob_pol = 1'b1;
    logic        blank_to_clamp = 1'b0;
    logic [7:0]  clamp_level = 8'h80;
    logic        gray_en = 1'b0;
    logic        hiz_en = 1'b0;
    logic        transparent = 1'b0;
    logic [11:0] dout;
    logic        dout_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pix_out_stage uut (
        .clk(clk), .rst_n(rst_n), .dclk_in(dclk_in), .dclk_pol(dclk_pol),
        .adc_data(adc_data), .pblk_in(pblk_in), .pblk_pol(pblk_pol),
        .clpob_in(clpob_in), .clpob_pol(clpob_pol),
        .blank_to_clamp(blank_to_clamp), .clamp_level(clamp_level),
        .gray_en(gray_en), .hiz_en(hiz_en), .transparent(transparent),
        .dout(dout), .dout_oe(dout_oe)
    );

    // Fields: data, pb raw, cl raw, pb pol, cl pol, blank_to_clamp, gray, clamp, expected
    localparam int NV = 11;
    localparam logic [37:0] VEC [NV] = '{
        {12'hA5C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h80, 12'hA5C}, // R2 plain binary
        {12'hA5C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, 12'hF72}, // R7 gray
        {12'h7FF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h80, 12'h000}, // R4 blank zero
        {12'h7FF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 12'h080}, // R5 blank clamp
        {12'h7FF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 12'h7FF}, // R6 clamp wins
        {12'h123, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 12'h080}, // R7 gray after blank
        {12'hFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, 12'h800}, // R7 all ones
        {12'h456, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 12'h000}, // R4 active-low blank
        {12'h456, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 12'h456}, // R4 active-low idle
        {12'h456, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 12'h456}, // R6 active-low clamp
        {12'h9AB, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C, 12'h03C}  // R5 other level
    };

    task automatic check(input logic [11:0] act, input logic [11:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        dclk_in = ~dclk_pol;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One data-clock period: active phase for one clk, idle for one clk.
    task automatic push(input logic [11:0] d, input logic pb, input logic cl);
        @(negedge clk);
        adc_data = d;
        pblk_in  = pb;
        clpob_in = cl;
        dclk_in  = dclk_pol;
        @(negedge clk);
        dclk_in  = ~dclk_pol;
    endtask

    task automatic idle_push(input int n);
        for (int k = 0; k < n; k++) push(12'h000, ~pblk_pol, ~clpob_pol);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check(dout, 12'h000, "R1 reset dout");
        check({11'd0, dout_oe}, 12'h001, "R8 oe after reset");

        // Table walk: one sample then eight idle periods, check after the ninth.
        for (int v = 0; v < NV; v++) begin
            logic [37:0] e;
            e = VEC[v];
            pblk_pol       = e[23];
            clpob_pol      = e[22];
            blank_to_clamp = e[21];
            gray_en        = e[20];
            clamp_level    = e[19:12];
            push(e[37:26], e[25], e[24]);
            idle_push(8);
            check(dout, e[11:0], $sformatf("R4/R5/R6/R7 vector %0d", v));
        end

        // R2: exact nine-edge latency
        pblk_pol = 1'b1; clpob_pol = 1'b1; gray_en = 1'b0; blank_to_clamp = 1'b0;
        do_reset();
        check(dout, 12'h000, "R1 second reset");
        push(12'h9A1, 1'b0, 1'b0);
        idle_push(7);
        check(dout, 12'h000, "R2 not yet after eight edges");
        idle_push(1);
        check(dout, 12'h9A1, "R2 visible after nine edges");

        // R3: no edge, no change
        repeat (10) @(negedge clk);
        check(dout, 12'h9A1, "R3 hold without edge");

        // R3: falling-edge data clock
        @(negedge clk);
        dclk_in  = 1'b1;
        dclk_pol = 1'b0;
        push(12'h3C5, 1'b0, 1'b0);
        idle_push(8);
        check(dout, 12'h3C5, "R3 falling-edge polarity");
        dclk_pol = 1'b1;
        dclk_in  = 1'b0;

        // R9: transparent mode one edge sooner
        do_reset();
        transparent = 1'b1;
        push(12'h777, 1'b0, 1'b0);
        idle_push(6);
        check(dout, 12'h000, "R9 not yet after seven edges");
        idle_push(1);
        check(dout, 12'h777, "R9 visible after eight edges");

        // R8: tri-state enable does not alter data
        @(negedge clk);
        hiz_en = 1'b1;
        @(negedge clk);
        check({11'd0, dout_oe}, 12'h000, "R8 oe low when released");
        check(dout, 12'h777, "R8 data unchanged");
        hiz_en = 1'b0;
        @(negedge clk);
        check({11'd0, dout_oe}, 12'h001, "R8 oe restored");
        transparent = 1'b0;

        // R10: strobe tied to its own sample
        do_reset();
        push(12'h111, 1'b1, 1'b0);
        push(12'h222, 1'b0, 1'b0);
        idle_push(7);
        check(dout, 12'h000, "R10 tagged sample blanked");
        idle_push(1);
        check(dout, 12'h222, "R10 next sample untouched");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule